// File: doc/BRIEF.md
# Keyed System Control Register Bank

This block is a small bank of board-level control and status registers. A processor reaches it over a simple 32-bit register bus: an address, a write strobe, a read strobe, write data and read data. The bank reports a fixed identity word, keeps an LED pattern and two sets of flag bits, shows the state of a memory card slot, and drives two side outputs: a one-cycle reset request and a two-bit display format select.

The identity word is a parameter. Its board-variant field, bits [27:16], decides which variant-specific behaviour the bank uses: whether a reset-control register exists, which of its bits triggers a reset, which display-control bits can be written, and where the card write-protect bit sits. The reset-control register is guarded by a key. It takes writes only while the lock register holds the exact key value 0xA05F. Any other value written to the lock register clears its bit 15, so a single stray write locks the bank again.

Flags are written through separate set and clear offsets, so software never needs a read-modify-write. Reads are registered: read data appears in the cycle after the read strobe and holds until the next read. Offsets that are not mapped read as zero, and writes to them have no effect.

Top module: `sysctl_bank`

## Requirements
- R1: Offset 0x000 reads the identity parameter. Writes there are ignored. The board variant is identity bits [27:16].
- R2: Offset 0x020 is the lock register and reads as 16 bits zero-extended. Writing the 32-bit value 0x0000A05F stores 0xA05F. Writing any other value stores wdata[15:0] & 0x7FFF.
- R3: Offset 0x040 is reset control. It exists on variants 0x100, 0x178 and 0x182, and on all other variants it reads zero. A write there is stored only while the lock holds 0xA05F. An accepted write with bit 8 set (variant 0x100), or with bit 2 set (variants 0x178 and 0x182), makes rst_req_o high for exactly the one cycle after the write edge.
- R4: Flags read at 0x030. A write to 0x030 ORs the data into the flags, and a write to 0x034 clears each flag whose data bit is 1. Non-volatile flags at 0x038 and 0x03C work the same way. The clear offsets read zero.
- R5: Display control at 0x050 resets to 0x1F00, or to 0 on variant 0x190. On variants 0x100 and 0x140, a write replaces every bit except [13:8]. On 0x178 and 0x182, a write replaces every bit except bit 7. All other variants ignore writes.
- R6: On variant 0x100, disp_sel_o takes bits [1:0] of each display-control write at the write edge. On other variants it stays 0.
- R7: Offset 0x048 reads card status. Bit 0 is card_det_i. wr_prot_i appears at bit 2 on variants 0x100 and 0x140, and at bit 1 on all other variants.
- R8: Offset 0x044 always reads 0x00000001, and offset 0x088 always reads 0xFF000000.
- R9: Unmapped offsets read zero. Writes to them change no register.
- R10: Offset 0x008 is a full 32-bit read/write LED register.
- R11: rdata_o is loaded on the clock edge where rd_en_i is high, and holds at other times. After reset every stored register except display control is zero, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | AW | Byte offset of the access |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| card_det_i | input | 1 | Card present level |
| wr_prot_i | input | 1 | Card write-protect level |
| rst_req_o | output | 1 | One-cycle reset request |
| disp_sel_o | output | 2 | Display format select |

## Verification
Read data is due one edge after the read strobe. The driver puts the expected word for each variant into a queue when it raises the strobe, and the monitor compares the word at the next falling edge, once the capturing edge has passed. Register writes take effect on their own edge, so a read issued in a later cycle sees the new value. The reset pulse and the display select are registered at the write edge, so they are sampled at the falling edge right after the write and again one cycle later, which confirms the pulse lasts a single cycle. Three instances with different variant fields share one bus, so every access checks all the variant rules at once.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DATA_W = 32;

  localparam int OFF_ID      = 'h000;
  localparam int OFF_LED     = 'h008;
  localparam int OFF_LOCK    = 'h020;
  localparam int OFF_FLG_SET = 'h030;
  localparam int OFF_FLG_CLR = 'h034;
  localparam int OFF_NVF_SET = 'h038;
  localparam int OFF_NVF_CLR = 'h03C;
  localparam int OFF_RSTCTL  = 'h040;
  localparam int OFF_BUSCTL  = 'h044;
  localparam int OFF_CARD    = 'h048;
  localparam int OFF_DISP    = 'h050;
  localparam int OFF_PROC1   = 'h088;

  localparam logic [31:0] LOCK_KEY   = 32'h0000_A05F;
  localparam logic [31:0] BUSCTL_VAL = 32'h0000_0001;
  localparam logic [31:0] PROC1_VAL  = 32'hFF00_0000;

  localparam logic [11:0] VAR_A  = 12'h100;
  localparam logic [11:0] VAR_E  = 12'h140;
  localparam logic [11:0] VAR_P8 = 12'h178;
  localparam logic [11:0] VAR_PX = 12'h182;
  localparam logic [11:0] VAR_VX = 12'h190;

  function automatic bit has_rstctl(logic [11:0] v);
    return (v == VAR_A) || (v == VAR_P8) || (v == VAR_PX);
  endfunction

  function automatic logic [31:0] rst_trig_mask(logic [11:0] v);
    return (v == VAR_A) ? 32'h0000_0100 : 32'h0000_0004;
  endfunction

  function automatic bit disp_writable(logic [11:0] v);
    return (v == VAR_A) || (v == VAR_E) || (v == VAR_P8) || (v == VAR_PX);
  endfunction

  // bits that keep their old value on a display-control write
  function automatic logic [31:0] disp_keep_mask(logic [11:0] v);
    return ((v == VAR_A) || (v == VAR_E)) ? 32'h0000_3F00 : 32'h0000_0080;
  endfunction

  function automatic logic [31:0] disp_reset(logic [11:0] v);
    return (v == VAR_VX) ? 32'h0 : 32'h0000_1F00;
  endfunction

  function automatic int wp_pos(logic [11:0] v);
    return ((v == VAR_A) || (v == VAR_E)) ? 2 : 1;
  endfunction
endpackage

// File: rtl/sysctl_lock.sv
module sysctl_lock
  import sysctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [15:0]       lock_o,
  output logic              unlocked_o
);
  logic [15:0] lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  lock_q <= '0;
    else if (wr_en_i) begin
      if (wdata_i == LOCK_KEY)    lock_q <= LOCK_KEY[15:0];
      else                        lock_q <= wdata_i[15:0] & 16'h7FFF;
    end
  end

  assign lock_o     = lock_q;
  assign unlocked_o = (lock_q == LOCK_KEY[15:0]);

  p_lock_relock_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wdata_i != LOCK_KEY) |=> !lock_o[15]);
  p_lock_key_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wdata_i == LOCK_KEY) |=> unlocked_o);
endmodule

// File: rtl/sysctl_setclr.sv
module sysctl_setclr #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_en_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= '0;
    else if (set_en_i) q <= q | wdata_i;
    else if (clr_en_i) q <= q & ~wdata_i;
  end

  assign q_o = q;

  p_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> ((q_o & $past(wdata_i)) == $past(wdata_i)));
  p_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !set_en_i) |=> ((q_o & $past(wdata_i)) == '0));
endmodule

// File: rtl/sysctl_rstctl.sv
module sysctl_rstctl
  import sysctl_pkg::*;
#(
  parameter logic [11:0] VARIANT = VAR_A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              unlocked_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] level_o,
  output logic              req_o
);
  localparam bit          PRESENT = has_rstctl(VARIANT);
  localparam logic [31:0] TRIG    = rst_trig_mask(VARIANT);

  logic [DATA_W-1:0] level_q;
  logic              req_q;
  logic              accept;

  assign accept = PRESENT && wr_en_i && unlocked_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
      req_q   <= 1'b0;
    end else begin
      req_q <= accept && ((wdata_i & TRIG) != '0);
      if (accept) level_q <= wdata_i;
    end
  end

  assign level_o = level_q;
  assign req_o   = req_q;

  p_req_keyed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> $past(wr_en_i && unlocked_i));
  p_hold_locked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked_i |=> $stable(level_o));
endmodule

// File: rtl/sysctl_disp.sv
module sysctl_disp
  import sysctl_pkg::*;
#(
  parameter logic [11:0] VARIANT = VAR_A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] disp_o,
  output logic [1:0]        sel_o
);
  localparam bit          WRITABLE = disp_writable(VARIANT);
  localparam logic [31:0] KEEP     = disp_keep_mask(VARIANT);
  localparam logic [31:0] RST_VAL  = disp_reset(VARIANT);

  logic [DATA_W-1:0] disp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    disp_q <= RST_VAL;
    else if (WRITABLE && wr_en_i)   disp_q <= (disp_q & KEEP) | (wdata_i & ~KEEP);
  end

  assign disp_o = disp_q;

  generate
    if (VARIANT == VAR_A) begin : g_mux
      logic [1:0] sel_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      sel_q <= '0;
        else if (wr_en_i) sel_q <= wdata_i[1:0];
      end
      assign sel_o = sel_q;
    end else begin : g_nomux
      assign sel_o = 2'b00;
    end
  endgenerate

  p_disp_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ((disp_o & KEEP) == ($past(disp_o) & KEEP)));
  p_disp_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!WRITABLE || !wr_en_i) |=> $stable(disp_o));
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
  import sysctl_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h0178_0000,
  parameter int          AW       = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              card_det_i,
  input  logic              wr_prot_i,
  output logic              rst_req_o,
  output logic [1:0]        disp_sel_o
);
  localparam logic [11:0] VARIANT = ID_VALUE[27:16];
  localparam int          WP_POS  = wp_pos(VARIANT);

  function automatic logic hit_at(logic [AW-1:0] a, int off);
    return a == AW'(off);
  endfunction

  logic              we_led, we_lock, we_fs, we_fc, we_ns, we_nc, we_rc, we_dp;
  logic [DATA_W-1:0] led_q, flags, nvflags, rst_level, disp, card, rd_mux, rdata_q;
  logic [15:0]       lock_val;
  logic              unlocked, hit;

  assign we_led  = wr_en_i && hit_at(addr_i, OFF_LED);
  assign we_lock = wr_en_i && hit_at(addr_i, OFF_LOCK);
  assign we_fs   = wr_en_i && hit_at(addr_i, OFF_FLG_SET);
  assign we_fc   = wr_en_i && hit_at(addr_i, OFF_FLG_CLR);
  assign we_ns   = wr_en_i && hit_at(addr_i, OFF_NVF_SET);
  assign we_nc   = wr_en_i && hit_at(addr_i, OFF_NVF_CLR);
  assign we_rc   = wr_en_i && hit_at(addr_i, OFF_RSTCTL);
  assign we_dp   = wr_en_i && hit_at(addr_i, OFF_DISP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     led_q <= '0;
    else if (we_led) led_q <= wdata_i;
  end

  sysctl_lock u_lock (
    .clk_i, .rst_ni, .wr_en_i(we_lock), .wdata_i,
    .lock_o(lock_val), .unlocked_o(unlocked)
  );

  sysctl_setclr #(.W(DATA_W)) u_flags (
    .clk_i, .rst_ni, .set_en_i(we_fs), .clr_en_i(we_fc), .wdata_i, .q_o(flags)
  );

  sysctl_setclr #(.W(DATA_W)) u_nvflags (
    .clk_i, .rst_ni, .set_en_i(we_ns), .clr_en_i(we_nc), .wdata_i, .q_o(nvflags)
  );

  sysctl_rstctl #(.VARIANT(VARIANT)) u_rstctl (
    .clk_i, .rst_ni, .wr_en_i(we_rc), .unlocked_i(unlocked), .wdata_i,
    .level_o(rst_level), .req_o(rst_req_o)
  );

  sysctl_disp #(.VARIANT(VARIANT)) u_disp (
    .clk_i, .rst_ni, .wr_en_i(we_dp), .wdata_i, .disp_o(disp), .sel_o(disp_sel_o)
  );

  always_comb begin
    card         = '0;
    card[0]      = card_det_i;
    card[WP_POS] = wr_prot_i;
  end

  always_comb begin
    rd_mux = '0;
    hit    = 1'b1;
    if      (hit_at(addr_i, OFF_ID))      rd_mux = ID_VALUE;
    else if (hit_at(addr_i, OFF_LED))     rd_mux = led_q;
    else if (hit_at(addr_i, OFF_LOCK))    rd_mux = {16'h0, lock_val};
    else if (hit_at(addr_i, OFF_FLG_SET)) rd_mux = flags;
    else if (hit_at(addr_i, OFF_NVF_SET)) rd_mux = nvflags;
    else if (hit_at(addr_i, OFF_RSTCTL))  rd_mux = rst_level;
    else if (hit_at(addr_i, OFF_BUSCTL))  rd_mux = BUSCTL_VAL;
    else if (hit_at(addr_i, OFF_CARD))    rd_mux = card;
    else if (hit_at(addr_i, OFF_DISP))    rd_mux = disp;
    else if (hit_at(addr_i, OFF_PROC1))   rd_mux = PROC1_VAL;
    else                                  hit    = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  p_id_read_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && hit_at(addr_i, OFF_ID)) |=> (rdata_o == ID_VALUE));
  p_unmapped_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !hit) |=> (rdata_o == '0));
  p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
  p_led_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_led |=> $stable(led_q));
endmodule

// File: tb/sysctl_bank_test.sv
module sysctl_bank_test;
  localparam logic [31:0] ID_A = 32'h0100_0A0B;
  localparam logic [31:0] ID_B = 32'h0178_0C0D;
  localparam logic [31:0] ID_C = 32'h0190_0E0F;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0;
  logic        card = 1'b0, wp = 1'b0;
  logic [31:0] rd [3];
  logic        req [3];
  logic [1:0]  sel [3];

  int total = 0, bad = 0;
  logic pend_q = 1'b0;
  logic [31:0] q_a[$], q_b[$], q_c[$];
  string q_tag[$];

  always #4 clk = ~clk;

  sysctl_bank #(.ID_VALUE(ID_A)) uut (
    .clk_i(clk), .rst_ni, .addr_i(addr), .wr_en_i(we), .rd_en_i(re), .wdata_i(wdata),
    .rdata_o(rd[0]), .card_det_i(card), .wr_prot_i(wp), .rst_req_o(req[0]), .disp_sel_o(sel[0]));
  sysctl_bank #(.ID_VALUE(ID_B)) uut_b (
    .clk_i(clk), .rst_ni, .addr_i(addr), .wr_en_i(we), .rd_en_i(re), .wdata_i(wdata),
    .rdata_o(rd[1]), .card_det_i(card), .wr_prot_i(wp), .rst_req_o(req[1]), .disp_sel_o(sel[1]));
  sysctl_bank #(.ID_VALUE(ID_C)) uut_c (
    .clk_i(clk), .rst_ni, .addr_i(addr), .wr_en_i(we), .rd_en_i(re), .wdata_i(wdata),
    .rdata_o(rd[2]), .card_det_i(card), .wr_prot_i(wp), .rst_req_o(req[2]), .disp_sel_o(sel[2]));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rdx(logic [11:0] a, logic [31:0] ea, logic [31:0] eb, logic [31:0] ec, string tag);
    @(negedge clk); addr = a; re = 1'b1;
    q_a.push_back(ea); q_b.push_back(eb); q_c.push_back(ec); q_tag.push_back(tag);
    @(negedge clk); re = 1'b0;
  endtask

  // outputs registered at the write edge: high now, low one cycle later
  task automatic chk_pulse(string tag, logic ea, logic eb);
    chk({tag, " req a"}, 32'(req[0]), 32'(ea));
    chk({tag, " req b"}, 32'(req[1]), 32'(eb));
    chk({tag, " req c"}, 32'(req[2]), 32'h0);
    @(negedge clk);
    chk({tag, " req a end"}, 32'(req[0]), 32'h0);
    chk({tag, " req b end"}, 32'(req[1]), 32'h0);
  endtask

  always @(posedge clk) pend_q <= re;

  always @(negedge clk) begin
    if (pend_q && q_tag.size() > 0) begin
      string t;
      t = q_tag.pop_front();
      chk({t, " a"}, rd[0], q_a.pop_front());
      chk({t, " b"}, rd[1], q_b.pop_front());
      chk({t, " c"}, rd[2], q_c.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R11 reset state
    chk("R11 rdata reset", rd[0], 32'h0);
    chk("R11 req reset", 32'(req[0]), 32'h0);
    chk("R11 sel reset", 32'(sel[0]), 32'h0);
    rdx(12'h020, 0, 0, 0, "R11 lock reset");
    rdx(12'h030, 0, 0, 0, "R11 flags reset");
    // R1
    rdx(12'h000, ID_A, ID_B, ID_C, "R1 id");
    wr(12'h000, 32'hFFFF_FFFF);
    rdx(12'h000, ID_A, ID_B, ID_C, "R1 id after write");
    // R5 reset values
    rdx(12'h050, 32'h1F00, 32'h1F00, 32'h0, "R5 disp reset");
    // R10
    wr(12'h008, 32'hDEAD_BEEF);
    rdx(12'h008, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R10 led");
    // R2
    wr(12'h020, 32'h0001_A05F);
    rdx(12'h020, 32'h205F, 32'h205F, 32'h205F, "R2 near-key");
    wr(12'h020, 32'h0000_FFFF);
    rdx(12'h020, 32'h7FFF, 32'h7FFF, 32'h7FFF, "R2 masked");
    // R3 locked
    wr(12'h040, 32'h104);
    chk_pulse("R3 locked", 1'b0, 1'b0);
    rdx(12'h040, 0, 0, 0, "R3 locked read");
    // R3 unlocked
    wr(12'h020, 32'h0000_A05F);
    rdx(12'h020, 32'hA05F, 32'hA05F, 32'hA05F, "R2 key");
    wr(12'h040, 32'h104);
    chk_pulse("R3 both bits", 1'b1, 1'b1);
    rdx(12'h040, 32'h104, 32'h104, 0, "R3 level");
    wr(12'h040, 32'h004);
    chk_pulse("R3 bit2", 1'b0, 1'b1);
    wr(12'h040, 32'h100);
    chk_pulse("R3 bit8", 1'b1, 1'b0);
    wr(12'h020, 32'h0000_1234);
    wr(12'h040, 32'h155);
    chk_pulse("R3 relocked", 1'b0, 1'b0);
    rdx(12'h040, 32'h100, 32'h100, 0, "R3 relocked level");
    // R4
    wr(12'h030, 32'h0000_00F0);
    wr(12'h030, 32'h0F00_0000);
    rdx(12'h030, 32'h0F00_00F0, 32'h0F00_00F0, 32'h0F00_00F0, "R4 set");
    wr(12'h034, 32'h0100_0030);
    rdx(12'h030, 32'h0E00_00C0, 32'h0E00_00C0, 32'h0E00_00C0, "R4 clear");
    rdx(12'h034, 0, 0, 0, "R4 clear offset");
    wr(12'h038, 32'hAAAA_0000);
    wr(12'h03C, 32'h2222_0000);
    rdx(12'h038, 32'h8888_0000, 32'h8888_0000, 32'h8888_0000, "R4 nv");
    rdx(12'h030, 32'h0E00_00C0, 32'h0E00_00C0, 32'h0E00_00C0, "R4 flags apart");
    // R5 / R6
    wr(12'h050, 32'h0000_00F3);
    chk("R6 sel a", 32'(sel[0]), 32'h3);
    chk("R6 sel b", 32'(sel[1]), 32'h0);
    chk("R6 sel c", 32'(sel[2]), 32'h0);
    rdx(12'h050, 32'h1FF3, 32'h73, 32'h0, "R5 disp write1");
    wr(12'h050, 32'h0000_2082);
    chk("R6 sel a2", 32'(sel[0]), 32'h2);
    rdx(12'h050, 32'h1F82, 32'h2002, 32'h0, "R5 disp write2");
    // R7
    card = 1'b1; wp = 1'b0;
    rdx(12'h048, 1, 1, 1, "R7 card");
    card = 1'b0; wp = 1'b1;
    rdx(12'h048, 4, 2, 2, "R7 wp");
    card = 1'b1;
    rdx(12'h048, 5, 3, 3, "R7 both");
    // R8
    rdx(12'h044, 1, 1, 1, "R8 busctl");
    wr(12'h044, 32'h0);
    rdx(12'h044, 1, 1, 1, "R8 busctl after write");
    rdx(12'h088, 32'hFF00_0000, 32'hFF00_0000, 32'hFF00_0000, "R8 proc1");
    // R9
    wr(12'h0FC, 32'hFFFF_FFFF);
    rdx(12'h0FC, 0, 0, 0, "R9 unmapped");
    rdx(12'h084, 0, 0, 0, "R9 unmapped 84");
    rdx(12'h008, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R9 led kept");
    rdx(12'h020, 32'h1234, 32'h1234, 32'h1234, "R9 lock kept");
    // R11 hold
    @(negedge clk); @(negedge clk);
    chk("R11 hold", rd[0], 32'h1234);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule